// File: doc/BRIEF.md
# Dual-Rate Parallel-to-Serial Transmitter

This block turns 10-bit encoded characters from a host into one serial bit stream. The host supplies a byte clock that runs at one twentieth of the bit clock. With full rate selected, the block loads a new character each time the byte clock changes level, so two characters go out per byte-clock period. With half rate selected, it loads only when the byte clock falls and sends each bit for two bit slots. The line rate then halves while the bit clock stays the same.

The block is modelled at bit-clock level. A system clock carries a bit enable, and every enabled cycle is one bit slot. The byte clock is a plain data input that the block samples in enabled cycles. A loopback control forces the external line to a constant 1, and the stream stays visible on an internal tap that feeds a receive path.

Top module: `dual_rate_serializer`

## Requirements
- R1: With `rate_full` = 1, a character is loaded from `par_data` in every enabled cycle where `byte_clk` differs from its value at the previous enabled cycle, on both rising and falling changes. Each bit is sent for one enabled cycle.
- R2: With `rate_full` = 0, a character is loaded only at a falling `byte_clk` change. A rising change loads nothing, and changes on `par_data` during the high phase have no effect on the output.
- R3: With `rate_full` = 0, each bit of the loaded character stays on the line for two consecutive enabled cycles.
- R4: Bit 0 of `par_data` is sent first and bit 9 last. A comma pattern whose leftmost symbol is held in bit 0 therefore leaves in its written left-to-right order.
- R5: While `loop_en` = 1, `ser_out` is 1 and `loop_tap` carries the serial stream. While `loop_en` = 0, `ser_out` equals `loop_tap`.
- R6: Synchronous active-high `rst` clears the line to 0. The line stays 0 until the first character is loaded.
- R7: The state advances only in cycles with `bit_en` = 1. Without the enable, the serial bit holds.
- R8: Bit 0 of a loaded character appears on the outputs one clock after the enabled edge at which the `byte_clk` change is sampled.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bit_en | input | 1 | Bit-slot enable, one pulse per serial bit time |
| byte_clk | input | 1 | Host byte clock, sampled in enabled cycles |
| par_data | input | 10 | Encoded character, bit 0 sent first |
| rate_full | input | 1 | 1 = load on both byte-clock edges, 0 = load on falling edge only |
| loop_en | input | 1 | 1 = hold external line at 1, stream on tap only |
| ser_out | output | 1 | External serial line |
| loop_tap | output | 1 | Serial stream for the internal receive path |

## Verification
The assertions assume that `byte_clk` and `par_data` change only between clock edges. They also assume that a `byte_clk` change is held until at least one enabled cycle has sampled it, and that `rate_full` is not switched in the middle of a character. The bench drives every input on the falling clock edge. It holds each byte-clock level for a full character time: ten enabled cycles at full rate, and ten per phase at half rate. It changes `rate_full` only while `rst` is asserted.

// File: rtl/dual_rate_serializer.sv
module dual_rate_serializer #(
  parameter int W = 10
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         bit_en,
  input  logic         byte_clk,
  input  logic [W-1:0] par_data,
  input  logic         rate_full,
  input  logic         loop_en,
  output logic         ser_out,
  output logic         loop_tap
);

  logic         bclk_q;
  logic [W-1:0] sh;
  logic         hold;
  logic         line_bit;
  logic         rise, fall, load;

  assign rise = bit_en & byte_clk & ~bclk_q;
  assign fall = bit_en & ~byte_clk & bclk_q;
  assign load = rate_full ? (rise | fall) : fall;

  always_ff @(posedge clk) begin
    if (rst) begin
      bclk_q   <= 1'b0;
      sh       <= '0;
      hold     <= 1'b0;
      line_bit <= 1'b0;
    end else if (bit_en) begin
      bclk_q <= byte_clk;
      if (load) begin
        line_bit <= par_data[0];
        sh       <= {1'b0, par_data[W-1:1]};
        hold     <= ~rate_full;
      end else if (hold) begin
        hold <= 1'b0;
      end else begin
        line_bit <= sh[0];
        sh       <= sh >> 1;
        hold     <= ~rate_full;
      end
    end
  end

  assign loop_tap = line_bit;
  assign ser_out  = loop_en ? 1'b1 : line_bit;

endmodule

// File: rtl/dual_rate_serializer_chk.sv
module dual_rate_serializer_chk #(
  parameter int W = 10
) (
  input logic         clk,
  input logic         rst,
  input logic         bit_en,
  input logic         byte_clk,
  input logic [W-1:0] par_data,
  input logic         rate_full,
  input logic         loop_en,
  input logic         ser_out,
  input logic         loop_tap
);

  logic bq;
  always_ff @(posedge clk) begin
    if (rst) bq <= 1'b0;
    else if (bit_en) bq <= byte_clk;
  end

  a_r1_full_load: assert property (@(posedge clk) disable iff (rst)
    (rate_full && bit_en && (byte_clk != bq)) |=> (loop_tap == $past(par_data[0])));

  a_r2_half_fall_load: assert property (@(posedge clk) disable iff (rst)
    (!rate_full && bit_en && !byte_clk && bq) |=> (loop_tap == $past(par_data[0])));

  a_r5_loop_line_high: assert property (@(posedge clk) disable iff (rst)
    loop_en |-> ser_out);

  a_r5_line_follows_tap: assert property (@(posedge clk) disable iff (rst)
    !loop_en |-> (ser_out == loop_tap));

  a_r7_hold_without_enable: assert property (@(posedge clk) disable iff (rst)
    !bit_en |=> $stable(loop_tap));

endmodule

bind dual_rate_serializer dual_rate_serializer_chk #(.W(W)) u_chk (
  .clk(clk), .rst(rst), .bit_en(bit_en), .byte_clk(byte_clk),
  .par_data(par_data), .rate_full(rate_full), .loop_en(loop_en),
  .ser_out(ser_out), .loop_tap(loop_tap)
);

// File: tb/sim_dual_rate_serializer.sv
module sim_dual_rate_serializer;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       bit_en = 1'b1;
  logic       byte_clk = 1'b0;
  logic [9:0] par_data = '0;
  logic       rate_full = 1'b1;
  logic       loop_en = 1'b0;
  logic       ser_out, loop_tap;

  int checks = 0;
  int fails = 0;

  always #4 clk = ~clk;

  dual_rate_serializer u0 (
    .clk(clk), .rst(rst), .bit_en(bit_en), .byte_clk(byte_clk),
    .par_data(par_data), .rate_full(rate_full), .loop_en(loop_en),
    .ser_out(ser_out), .loop_tap(loop_tap)
  );

  // {character, expected stream with the first bit sent in the MSB}
  localparam logic [19:0] VEC [8] = '{
    {10'h17C, 10'h0FA}, {10'h000, 10'h000}, {10'h3FF, 10'h3FF},
    {10'h001, 10'h200}, {10'h200, 10'h001}, {10'h155, 10'h2AA},
    {10'h2AA, 10'h155}, {10'h283, 10'h305}
  };

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%b expected=%b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic do_reset(input logic bc, input logic full);
    rst = 1'b1; bit_en = 1'b1; byte_clk = bc; rate_full = full; par_data = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
  endtask

  initial begin
    #(8 * 200000);
    fails++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails + 1, checks + 1);
    $finish;
  end

  initial begin
    // R6: reset state, no load while byte clock is idle
    do_reset(1'b0, 1'b1);
    chk("R6 reset line", ser_out, 1'b0);
    chk("R6 reset tap", loop_tap, 1'b0);
    par_data = 10'h3FF;
    repeat (5) begin @(negedge clk); chk("R6 idle before load", ser_out, 1'b0); end

    // R1 R4 R8: table walk at full rate, one character per byte-clock edge
    for (int v = 0; v < 8; v++) begin
      par_data = VEC[v][19:10];
      byte_clk = ~byte_clk;
      for (int j = 0; j < 10; j++) begin
        @(negedge clk);
        chk(j == 0 ? "R8 first bit latency" : "R1 R4 full-rate order", ser_out, VEC[v][9-j]);
      end
    end

    // R5: loopback holds line high, tap carries the stream
    loop_en = 1'b1;
    for (int v = 0; v < 3; v++) begin
      par_data = VEC[v][19:10];
      byte_clk = ~byte_clk;
      for (int j = 0; j < 10; j++) begin
        @(negedge clk);
        chk("R5 loop line high", ser_out, 1'b1);
        chk("R5 loop tap stream", loop_tap, VEC[v][9-j]);
      end
    end
    loop_en = 1'b0;

    // R7: enable on every other cycle, each bit held two clocks
    par_data = 10'h283;
    byte_clk = ~byte_clk;
    for (int j = 0; j < 20; j++) begin
      @(negedge clk);
      chk("R7 enable gating", ser_out, par_data[j/2]);
      bit_en = (j % 2 == 1);
    end
    bit_en = 1'b1;

    // R2 R3: half rate, falling edge loads, rising edge ignored
    do_reset(1'b1, 1'b0);
    repeat (4) begin @(negedge clk); chk("R2 rise after reset no load", ser_out, 1'b0); end
    for (int v = 0; v < 8; v++) begin
      logic [9:0] d;
      d = VEC[v][19:10];
      par_data = d;
      byte_clk = 1'b0;
      for (int j = 0; j < 10; j++) begin
        @(negedge clk);
        chk("R3 half-rate bits 0-4 doubled", ser_out, d[j/2]);
      end
      par_data = ~d;
      byte_clk = 1'b1;
      for (int j = 0; j < 10; j++) begin
        @(negedge clk);
        chk("R2 rising edge ignored, R3 bits 5-9", ser_out, d[5 + j/2]);
      end
    end

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule